// File: doc/BRIEF.md
# Breakpoint Controller with Run-Time Counter

The block sits between the decode stage of a CPU and the debug logic. When the CPU decodes the break opcode (00h), it raises a one-cycle strobe. The block then either does nothing or stops the CPU. With breakpoints enabled, the strobe puts the block into debug mode and holds the CPU idle. With breakpoints disabled, the strobe is dropped and the break instruction runs as a no-op.

Debug mode ends only when the host raises a one-cycle resume request. A 16-bit counter measures how many system clock cycles the CPU has run since the last resume. It clears when debug mode is left and counts every cycle spent outside debug mode. It stops at FFFFh and does not wrap. While the block is in debug mode the counter holds still, so the host can read it.

Top module: `brk_run_ctrl`

## Requirements
- R1: After reset, `debug_mode_o` and `cpu_idle_o` are 0, `run_count_o` is 0 and breakpoints are disabled.
- R2: Suppose breakpoints are enabled, the block is outside debug mode and `brk_i` is 1 at a clock edge. Then `debug_mode_o` and `cpu_idle_o` are 1 from that edge on.
- R3: While breakpoints are disabled, `brk_i` has no effect on any output. The break acts as a no-op.
- R4: A cycle with `en_we_i`=1 loads `en_wdata_i` into the enable bit (1 = enabled). A break strobe in the same cycle is judged by the old value of the bit.
- R5: At each clock edge where the block is outside debug mode, `run_count_o` increases by 1.
- R6: `run_count_o` stays at FFFFh once it reaches that value and never wraps to 0.
- R7: While in debug mode, `run_count_o` does not change.
- R8: If `resume_i`=1 at an edge while in debug mode, then from that edge on `debug_mode_o` and `cpu_idle_o` are 0 and `run_count_o` is 0.
- R9: `resume_i` outside debug mode has no effect.
- R10: `brk_i` in debug mode has no effect. The block stays in debug mode and the counter holds.
- R11: `cpu_idle_o` always equals `debug_mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| brk_i | input | 1 | One-cycle strobe: break opcode decoded |
| resume_i | input | 1 | One-cycle host request to leave debug mode |
| en_we_i | input | 1 | Write strobe for the breakpoint-enable bit |
| en_wdata_i | input | 1 | New value of the enable bit (1 = enabled) |
| cpu_idle_o | output | 1 | Holds the CPU idle |
| debug_mode_o | output | 1 | Block is in debug mode |
| run_count_o | output | 16 | Cycles run since the last resume, saturating |

## Verification
The case hardest to reach from the ports is the counter pinned at FFFFh. The stimulus gets there with an uninterrupted run of more than 65,535 cycles outside debug mode. The bench then enters debug mode from the saturated value and resumes, checking that the counter restarts from zero. A second hard case is a break strobe in the same cycle as an enable write. This separates the old and new values of the enable bit.

// File: rtl/brk_run_pkg.sv
package brk_run_pkg;
  localparam int unsigned CNT_W = 16;
  typedef logic [CNT_W-1:0] run_cnt_t;
endpackage

// File: rtl/brk_mode_ctrl.sv
module brk_mode_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic brk_i,
  input  logic resume_i,
  input  logic en_we_i,
  input  logic en_wdata_i,
  output logic debug_o,
  output logic en_o,
  output logic exit_o
);
  logic debug_q, en_q;
  logic enter;

  assign enter  = brk_i & en_q & ~debug_q;
  assign exit_o = resume_i & debug_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      debug_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      if (enter)       debug_q <= 1'b1;
      else if (exit_o) debug_q <= 1'b0;
      if (en_we_i)     en_q    <= en_wdata_i;
    end
  end

  assign debug_o = debug_q;
  assign en_o    = en_q;
endmodule

// File: rtl/brk_run_counter.sv
module brk_run_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         clear_i,
  output logic [W-1:0] count_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clear_i)                 cnt_q <= '0;
    else if (run_i && cnt_q != MAX)   cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/brk_run_ctrl.sv
module brk_run_ctrl
  import brk_run_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       brk_i,
  input  logic       resume_i,
  input  logic       en_we_i,
  input  logic       en_wdata_i,
  output logic       cpu_idle_o,
  output logic       debug_mode_o,
  output run_cnt_t   run_count_o
);
  logic debug, brk_en, exit_dbg;

  brk_mode_ctrl i_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .brk_i      (brk_i),
    .resume_i   (resume_i),
    .en_we_i    (en_we_i),
    .en_wdata_i (en_wdata_i),
    .debug_o    (debug),
    .en_o       (brk_en),
    .exit_o     (exit_dbg)
  );

  brk_run_counter #(.W(CNT_W)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (~debug),
    .clear_i (exit_dbg),
    .count_o (run_count_o)
  );

  assign debug_mode_o = debug;
  assign cpu_idle_o   = debug;
endmodule

// File: rtl/brk_run_ctrl_chk.sv
module brk_run_ctrl_chk
  import brk_run_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     brk_i,
  input logic     resume_i,
  input logic     en_q_i,
  input logic     cpu_idle_o,
  input logic     debug_mode_o,
  input run_cnt_t run_count_o
);
  localparam run_cnt_t MAX = '1;

  a_r2_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!debug_mode_o && brk_i && en_q_i) |=> debug_mode_o);
  a_r3_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!debug_mode_o && !en_q_i) |=> !debug_mode_o);
  a_r5_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!debug_mode_o && run_count_o != MAX) |=> run_count_o == $past(run_count_o) + 1'b1);
  a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!debug_mode_o && run_count_o == MAX) |=> run_count_o == MAX);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (debug_mode_o && !resume_i) |=> (debug_mode_o && $stable(run_count_o)));
  a_r8_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (debug_mode_o && resume_i) |=> (!debug_mode_o && !cpu_idle_o && run_count_o == '0));
  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_idle_o == debug_mode_o);
endmodule

bind brk_run_ctrl brk_run_ctrl_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .brk_i        (brk_i),
  .resume_i     (resume_i),
  .en_q_i       (brk_en),
  .cpu_idle_o   (cpu_idle_o),
  .debug_mode_o (debug_mode_o),
  .run_count_o  (run_count_o)
);

// File: tb/test_brk_run_ctrl.sv
`timescale 1ns/1ps
module test_brk_run_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic brk = 1'b0, res = 1'b0, we = 1'b0, wd = 1'b0;
  logic idle, dbg;
  logic [15:0] cnt;

  int checks = 0, failures = 0;
  int m_dbg = 0, m_en = 0, m_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  brk_run_ctrl i_brk_run_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .brk_i(brk), .resume_i(res),
    .en_we_i(we), .en_wdata_i(wd),
    .cpu_idle_o(idle), .debug_mode_o(dbg), .run_count_o(cnt)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(int'(dbg), m_dbg, {tag, " debug"});
    chk(int'(idle), m_dbg, {tag, " idle (R11)"});
    chk(int'(cnt), m_cnt, {tag, " count"});
  endtask

  task automatic step(input logic b, input logic r, input logic w, input logic d,
                      input string tag);
    brk = b; res = r; we = w; wd = d;
    @(posedge clk);
    if (m_dbg != 0) begin
      if (r) begin m_dbg = 0; m_cnt = 0; end
    end else begin
      if (b && m_en != 0) m_dbg = 1;
      if (m_cnt < 65535) m_cnt++;
    end
    if (w) m_en = int'(d);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #5_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    step(1, 0, 0, 0, "R1 break disabled after reset");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, "R5 counting");
    step(1, 0, 0, 0, "R3 break ignored");
    step(1, 0, 1, 1, "R4 same-cycle enable uses old bit");
    step(0, 0, 0, 0, "R5 counting");
    step(1, 0, 0, 0, "R2 enter debug");
    for (int i = 0; i < 6; i++) step(i[0], 0, 0, 0, "R10 R7 hold in debug");
    step(0, 1, 0, 0, "R8 resume clears");
    for (int i = 0; i < 20; i++) step(0, (i == 7), 0, 0, "R9 resume outside ignored");
    step(1, 0, 0, 0, "R2 enter again");
    step(0, 1, 0, 0, "R8 resume");
    for (int i = 0; i < 70000; i++) step(0, 0, 0, 0, "R6 saturate");
    step(1, 0, 0, 0, "R6 enter at max");
    step(0, 0, 0, 0, "R7 hold at max");
    step(0, 1, 0, 0, "R8 resume from max");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R5 restart");
    step(0, 0, 1, 0, "R4 disable");
    step(1, 0, 0, 0, "R3 ignored after disable");
    step(1, 1, 0, 0, "R3 R9 ignored");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule